// File: doc/BRIEF.md
# Latched Bus Event Status and Interrupt Registers

This block holds the host-visible status byte and interrupt cause byte of a parallel bus controller. Event logic elsewhere in the controller raises one-cycle pulses for errors (gross error, parity error, terminal count, valid group code) and for bus events (bus reset seen, illegal command, disconnect or timeout, service request, function complete, reselected, selected with attention, selected). This block makes each pulse sticky. The three bus phase lines pass through to the low bits of the status byte without any latching. An interrupt flag is raised whenever any cause bit is latched.

The host reads either byte through a small read port. The read data is combinational and shows the value before any clear. A read of the cause byte clears every latched bit at that clock edge: the cause bits, status bits 6:3 and the interrupt flag. The phase bits are not affected. A software reset pulse clears the same bits. The interrupt flag is set whatever the enable says. The enable only gates the interrupt pin. A small two-state machine, with states IRQ_IDLE and IRQ_PEND, owns the flag. It takes the transition IDLE->PEND on any cause pulse, the transition PEND->IDLE on a clear with no new pulse, and holds its state otherwise. A pulse that arrives in the same cycle as a clear always wins.

Top module: `bus_evt_status`

## Requirements
- R1: While and after rst_n is low, the status byte read back is 0 in bits 7:3, the cause byte is 0x00 and irq_o is 0.
- R2: A pulse on st_evt sets status bits and they stay set. The mapping is st_evt[3] gross error to bit 6, st_evt[2] parity error to bit 5, st_evt[1] terminal count to bit 4, and st_evt[0] valid group code to bit 3. The status byte is read with rd_sel=0.
- R3: Status bits 2:0 equal phase_in in the same cycle. The phase lines are MSG on bit 2, C/D on bit 1 and I/O on bit 1 0. All eight codes pass through unchanged, including the invalid codes 4 and 5. The valid codes are 0 data out, 1 data in, 2 command, 3 status, 6 message out and 7 message in.
- R4: A pulse on cause_evt[i] sets bit i of the cause byte (read with rd_sel=1) until it is cleared. The bits are 7 bus reset, 6 illegal command, 5 disconnect/timeout, 4 service request, 3 function complete, 2 reselected, 1 selected with attention, 0 selected.
- R5: A cycle with rd_en=1 and rd_sel=1 returns the cause byte as it was before the clear. From the next cycle on, all cause bits, status bits 6:3 and the interrupt flag are 0.
- R6: soft_rst high at a clock edge clears the same bits as R5.
- R7: An event pulse that arrives in the same cycle as a clearing read or a soft reset is latched, not lost.
- R8: Status bit 7 is 1 exactly when any cause bit is latched, whatever the value of irq_en.
- R9: irq_o is 1 exactly when status bit 7 is 1 and irq_en is 1. It follows irq_en within the same cycle.
- R10: A status read (rd_en=1, rd_sel=0) clears nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hardware reset, active low |
| soft_rst | input | 1 | Software reset pulse; clears latched bits |
| st_evt | input | STAT_W | Error event pulses into status bits 6:3 |
| cause_evt | input | CAUSE_W | Bus event pulses into the cause byte |
| phase_in | input | PHASE_W | Live bus phase lines |
| irq_en | input | 1 | Interrupt pin enable |
| rd_en | input | 1 | Host read strobe |
| rd_sel | input | 1 | 0 selects the status byte, 1 selects the cause byte |
| rd_data | output | RD_W | Selected byte, combinational |
| irq_o | output | 1 | Interrupt request pin |

## Verification
The bench builds the block with its default parameter values: four status event bits, eight cause bits and three phase lines. These values make both read bytes exactly 8 bits wide, so every bit position and phase code above can be checked with exact byte values. They also let the bench sweep each cause bit on its own, walk all eight phase codes, and hit the case where a pulse and a clear land in the same cycle for both the status byte and the cause byte.

// File: rtl/bus_evt_pkg.sv
`timescale 1ns/1ps
package bus_evt_pkg;
    typedef enum logic {
        IRQ_IDLE = 1'b0,
        IRQ_PEND = 1'b1
    } irq_state_e;
endpackage

// File: rtl/evt_latch.sv
`timescale 1ns/1ps
// Sticky bit vector: pulses set bits, a clear empties it, pulses win over clear.
module evt_latch #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic [W-1:0] evt,
    output logic [W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= (clr ? '0 : q) | evt;
    end

    // R4: without a clear, no latched bit drops
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ((q & $past(q)) == $past(q)));
    // R5: a clear with no new pulse empties the vector
    a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && evt == '0) |=> (q == '0));
    // R7: every pulse is visible on the next cycle, clear or not
    a_r7_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (evt != '0) |=> ((q & $past(evt)) == $past(evt)));
endmodule

// File: rtl/irq_ctrl.sv
`timescale 1ns/1ps
// Interrupt flag state machine with gated output pin.
module irq_ctrl
    import bus_evt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    input  logic en,
    output logic flag,
    output logic irq_o
);
    irq_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= IRQ_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_IDLE: if (set) state_d = IRQ_PEND;
            IRQ_PEND: if (clr && !set) state_d = IRQ_IDLE;
            default:  state_d = IRQ_IDLE;
        endcase
    end

    always_comb begin
        flag  = (state_q == IRQ_PEND);
        irq_o = flag && en;
    end

    // R9: the pin never rises while disabled
    a_r9_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> !irq_o);
    // R7: a set in a clearing cycle leaves the flag raised
    a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set |=> flag);
endmodule

// File: rtl/bus_evt_status.sv
`timescale 1ns/1ps
module bus_evt_status #(
    parameter int STAT_W  = 4,
    parameter int CAUSE_W = 8,
    parameter int PHASE_W = 3,
    localparam int STAT_BYTE_W = 1 + STAT_W + PHASE_W,
    localparam int RD_W = (STAT_BYTE_W > CAUSE_W) ? STAT_BYTE_W : CAUSE_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               soft_rst,
    input  logic [STAT_W-1:0]  st_evt,
    input  logic [CAUSE_W-1:0] cause_evt,
    input  logic [PHASE_W-1:0] phase_in,
    input  logic               irq_en,
    input  logic               rd_en,
    input  logic               rd_sel,
    output logic [RD_W-1:0]    rd_data,
    output logic               irq_o
);
    logic               clr_all;
    logic [STAT_W-1:0]  stat_q;
    logic [CAUSE_W-1:0] cause_q;
    logic               irq_flag;

    assign clr_all = soft_rst | (rd_en & rd_sel);

    evt_latch #(.W(STAT_W)) u_stat (
        .clk(clk), .rst_n(rst_n), .clr(clr_all), .evt(st_evt), .q(stat_q)
    );

    evt_latch #(.W(CAUSE_W)) u_cause (
        .clk(clk), .rst_n(rst_n), .clr(clr_all), .evt(cause_evt), .q(cause_q)
    );

    irq_ctrl u_irq (
        .clk(clk), .rst_n(rst_n), .set(|cause_evt), .clr(clr_all),
        .en(irq_en), .flag(irq_flag), .irq_o(irq_o)
    );

    always_comb begin
        if (rd_sel) rd_data = RD_W'(cause_q);
        else        rd_data = RD_W'({irq_flag, stat_q, phase_in});
    end

    // R8: the flag held by the state machine agrees with the cause latch
    a_r8_flag_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        irq_flag == (cause_q != '0));
    // R10: a status read leaves the latched status untouched
    a_r10_no_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !rd_sel && !soft_rst) |=> ((stat_q & $past(stat_q)) == $past(stat_q)));
    // R1: outputs are quiet straight after reset
    a_r1_reset: assert property (@(posedge clk)
        $rose(rst_n) |-> (cause_q == '0 && !irq_o));
endmodule

// File: tb/bus_evt_status_tb.sv
`timescale 1ns/1ps
module bus_evt_status_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       soft_rst = 1'b0;
    logic [3:0] st_evt = '0;
    logic [7:0] cause_evt = '0;
    logic [2:0] phase_in = '0;
    logic       irq_en = 1'b0;
    logic       rd_en = 1'b0;
    logic       rd_sel = 1'b0;
    logic [7:0] rd_data;
    logic       irq_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bus_evt_status dut_i (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .st_evt(st_evt),
        .cause_evt(cause_evt), .phase_in(phase_in), .irq_en(irq_en),
        .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data), .irq_o(irq_o)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic pulse(input logic [7:0] c, input logic [3:0] s);
        cause_evt = c; st_evt = s;
        step();
        cause_evt = '0; st_evt = '0;
    endtask

    task automatic peek(input logic sel, output logic [7:0] v);
        rd_en = 1'b0; rd_sel = sel; #1; v = rd_data;
    endtask

    task automatic read_cause(output logic [7:0] v);
        rd_en = 1'b1; rd_sel = 1'b1; #1; v = rd_data;
        step();
        rd_en = 1'b0; rd_sel = 1'b0; #1;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        phase_in = 3'd0;
        peek(1'b0, v); check("R1 status", v, 8'h00);
        peek(1'b1, v); check("R1 cause", v, 8'h00);
        check("R1 irq", {7'd0, irq_o}, 8'h00);
    endtask

    task automatic t_status_latch();
        logic [7:0] v;
        phase_in = 3'd3;
        pulse(8'h00, 4'b1010);
        step();
        peek(1'b0, v); check("R2 gross+tc latched", v, 8'h53);
        rd_en = 1'b1; rd_sel = 1'b0; step(); step(); rd_en = 1'b0;
        peek(1'b0, v); check("R10 status read keeps", v, 8'h53);
        pulse(8'h00, 4'b0101);
        peek(1'b0, v); check("R2 all four", v, 8'h7B);
        read_cause(v); check("R5 cause read value", v, 8'h00);
        peek(1'b0, v); check("R5 status cleared", v, 8'h03);
    endtask

    task automatic t_phase();
        logic [7:0] v;
        for (int p = 0; p < 8; p++) begin
            phase_in = 3'(p);
            peek(1'b0, v); check("R3 live phase", v, 8'(p));
        end
        phase_in = 3'd0;
    endtask

    task automatic t_cause_irq();
        logic [7:0] v;
        irq_en = 1'b0;
        pulse(8'h81, 4'b0000);
        peek(1'b1, v); check("R4 cause latched", v, 8'h81);
        peek(1'b0, v); check("R8 flag while disabled", v, 8'h80);
        check("R9 pin gated off", {7'd0, irq_o}, 8'h00);
        irq_en = 1'b1; #1;
        check("R9 pin on", {7'd0, irq_o}, 8'h01);
        read_cause(v); check("R5 read returns pre-clear", v, 8'h81);
        peek(1'b1, v); check("R5 cause cleared", v, 8'h00);
        peek(1'b0, v); check("R5 flag cleared", v, 8'h00);
        check("R9 pin cleared", {7'd0, irq_o}, 8'h00);
    endtask

    task automatic t_soft_reset();
        logic [7:0] v;
        pulse(8'h10, 4'b0001);
        soft_rst = 1'b1; step(); soft_rst = 1'b0; #1;
        peek(1'b1, v); check("R6 cause cleared", v, 8'h00);
        peek(1'b0, v); check("R6 status cleared", v, 8'h00);
        check("R6 irq cleared", {7'd0, irq_o}, 8'h00);
    endtask

    task automatic t_same_cycle();
        logic [7:0] v;
        phase_in = 3'd6;
        pulse(8'h01, 4'b0000);
        rd_en = 1'b1; rd_sel = 1'b1; cause_evt = 8'h20; st_evt = 4'b0100; #1;
        v = rd_data; check("R7 read shows old", v, 8'h01);
        step();
        rd_en = 1'b0; cause_evt = '0; st_evt = '0;
        peek(1'b1, v); check("R7 cause kept", v, 8'h20);
        peek(1'b0, v); check("R7 status kept", v, 8'hA6);
        check("R7 irq kept", {7'd0, irq_o}, 8'h01);
        soft_rst = 1'b1; cause_evt = 8'h04; step();
        soft_rst = 1'b0; cause_evt = '0; #1;
        peek(1'b1, v); check("R7 kept over soft reset", v, 8'h04);
        read_cause(v);
        phase_in = 3'd0;
    endtask

    task automatic t_each_bit();
        logic [7:0] v;
        for (int i = 0; i < 8; i++) begin
            pulse(8'(1 << i), 4'b0000);
            peek(1'b1, v); check("R4 single bit", v, 8'(1 << i));
            peek(1'b0, v); check("R8 flag per bit", v, 8'h80);
            read_cause(v);
        end
    endtask

    initial begin
        repeat (3) step();
        t_reset();
        rst_n = 1'b1;
        step();
        t_reset();
        t_status_latch();
        t_phase();
        t_cause_irq();
        t_soft_reset();
        t_same_cycle();
        t_each_bit();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end
endmodule